// File: doc/BRIEF.md
# Iterative RC6 Block Cipher Core

This block encrypts or decrypts one four-word RC6 block at a time. Its datapath is iterative and completes one round per clock cycle. The expanded round-key table is loaded word by word through a handshaked key port. It is kept in an internal key store, which the controller addresses by round number. A block enters through a handshaked input port, and the direction input is sampled when the block is accepted. After the whitening steps and the rounds, the result waits on the output port until the downstream side reports room.

Key scheduling from a user key is not part of the block; the expanded table is loaded as is. The word width `W` and the round count `R` are fixed at synthesis time. The defaults are W = 32 and R = 20, which gives a table of 2R+4 = 44 words.

Top module: `rc6_iter_core`

## Requirements
- R1: After reset, `ready` is 1 and `blk_take`, `blk_write` and `key_take` are 0.
- R2: While the core is idle, `key_take` equals `key_avail`. Each accepted key word is stored at the next table index. Indices start at 0 after reset and wrap from 2R+3 back to 0, so a second full load replaces the whole table.
- R3: Blocks are packed as {D, C, B, A}, with A in bits W-1:0 of `blk_in` and `blk_out`. `dir_dec` = 1 selects decryption and 0 selects encryption. Its value is taken only in the cycle in which `blk_take` is high.
- R4: When the core is idle and `blk_avail` is 1 with `key_avail` 0, `blk_take` is 1 for that cycle and `ready` is 0 in the next cycle. While `key_avail` is 1, no block is taken.
- R5: Encryption computes the following, where f(x) is (x·(2x+1) mod 2^W) rotated left by log2 W, XOR is the combining operation, rotation amounts are the low log2 W bits, and all sums are mod 2^W:
  - First, B += S[0] and D += S[1].
  - Then, for each round i = 1..R, t = f(B) and u = f(D). A becomes rotl(A^t, u) + S[2i] and C becomes rotl(C^u, t) + S[2i+1]. The words then move so that (A,B,C,D) becomes (B,C,D,A).
  - Finally, A += S[2R+2] and C += S[2R+3].
- R6: Decryption is the exact inverse of R5 under the same table. It uses S[2R+3] and S[2R+2] first, rounds R down to 1, and S[1] and S[0] last. Decrypting a ciphertext returns the original plaintext.
- R7: With `out_full` at 0, `blk_write` goes high in the cycle R+2 cycles after the cycle in which `blk_take` was high.
- R8: While a result waits and `out_full` is 1, `blk_write` stays 0 and `blk_out` holds steady. No new block is taken until the result has been written.
- R9: `blk_write` is high for exactly one cycle per result, and `ready` is 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_dec | input | 1 | 1 = decrypt, 0 = encrypt, sampled at block acceptance |
| blk_in | input | 4W | Input block {D,C,B,A} |
| blk_avail | input | 1 | Input block is offered |
| blk_take | output | 1 | Input block is accepted at this clock edge |
| blk_out | output | 4W | Result block {D,C,B,A} |
| blk_write | output | 1 | Result is written at this clock edge |
| out_full | input | 1 | Downstream cannot accept a result |
| key_word | input | W | Round-key table word to load |
| key_avail | input | 1 | Key word is offered |
| key_take | output | 1 | Key word is stored at this clock edge |
| ready | output | 1 | Core is idle |

## Verification
Encryption is tried with an all-zero block, an all-ones block, a fixed ascending pattern and several pseudo-random blocks. Each result is compared with a reference model written independently in the bench.
- The extreme patterns show whether the carries of the mod 2^W additions are handled correctly.
- The random blocks exercise many rotation amounts, which separates left from right rotation and catches a wrong rotation-amount field.

Each ciphertext is then decrypted and must give back its plaintext. This catches any misordered key use or word reordering in the inverse rounds.

A second table load checks that the key index wraps, since the results must then follow the new keys. A hold with `out_full` high checks back-pressure and that no new block is accepted during the hold.

// File: rtl/rc6_pkg.sv
package rc6_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ROUND,
    ST_POST,
    ST_OUT
  } rc6_state_e;
endpackage

// File: rtl/rc6_keymem.sv
module rc6_keymem #(
  parameter int W = 32,
  parameter int R = 20
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [W-1:0]                wr_data,
  input  logic [$clog2(R+2)-1:0]      rd_pair,
  output logic [W-1:0]                key_even,
  output logic [W-1:0]                key_odd
);
  localparam int NK = 2*R + 4;
  localparam int NP = R + 2;
  localparam int PW = $clog2(NP);
  localparam int KW = PW + 1;

  logic [W-1:0]  mem [NK];
  logic [KW-1:0] wptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      for (int i = 0; i < NK; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wptr] <= wr_data;
      wptr      <= (wptr == KW'(NK-1)) ? '0 : wptr + KW'(1);
    end
  end

  // a pair holds S[2p] and S[2p+1]
  assign key_even = mem[{rd_pair, 1'b0}];
  assign key_odd  = mem[{rd_pair, 1'b1}];

  // R2
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wptr == KW'(NK-1)) |=> (wptr == '0));

  // R2
  key_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem[$past(wptr)] == $past(wr_data)));
endmodule

// File: rtl/rc6_round.sv
module rc6_round #(
  parameter int W = 32
) (
  input  logic         dec_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  input  logic [W-1:0] d_i,
  input  logic [W-1:0] ke_i,
  input  logic [W-1:0] ko_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o,
  output logic [W-1:0] c_o,
  output logic [W-1:0] d_o
);
  localparam int LGW = $clog2(W);

  function automatic logic [W-1:0] rotl_f(input logic [W-1:0] x, input logic [LGW-1:0] n);
    logic [2*W-1:0] dbl;
    dbl = {x, x} << n;
    return dbl[2*W-1:W];
  endfunction

  function automatic logic [W-1:0] rotr_f(input logic [W-1:0] x, input logic [LGW-1:0] n);
    logic [2*W-1:0] dbl;
    dbl = {x, x} >> n;
    return dbl[W-1:0];
  endfunction

  function automatic logic [W-1:0] mix_f(input logic [W-1:0] x);
    logic [W-1:0] p;
    p = x * ((x << 1) | W'(1));
    return rotl_f(p, LGW'(LGW));
  endfunction

  // forward round
  logic [W-1:0] et, eu, ea, ec;
  assign et = mix_f(b_i);
  assign eu = mix_f(d_i);
  assign ea = rotl_f(a_i ^ et, eu[LGW-1:0]) + ke_i;
  assign ec = rotl_f(c_i ^ eu, et[LGW-1:0]) + ko_i;

  // inverse round: words first reordered to (D,A,B,C)
  logic [W-1:0] dt, du, da, dc;
  assign du = mix_f(c_i);
  assign dt = mix_f(a_i);
  assign dc = rotr_f(b_i - ko_i, dt[LGW-1:0]) ^ du;
  assign da = rotr_f(d_i - ke_i, du[LGW-1:0]) ^ dt;

  always_comb begin
    if (dec_i) begin
      a_o = da;
      b_o = a_i;
      c_o = dc;
      d_o = c_i;
    end else begin
      a_o = b_i;
      b_o = ec;
      c_o = d_i;
      d_o = ea;
    end
  end
endmodule

// File: rtl/rc6_ctrl.sv
module rc6_ctrl
  import rc6_pkg::*;
#(
  parameter int R = 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   dir_dec,
  input  logic                   blk_avail,
  input  logic                   key_avail,
  input  logic                   out_full,
  output rc6_state_e             st_o,
  output logic [$clog2(R+2)-1:0] key_pair,
  output logic                   dec_mode,
  output logic                   load_en,
  output logic                   round_en,
  output logic                   post_en,
  output logic                   key_take,
  output logic                   blk_write,
  output logic                   ready
);
  localparam int NP = R + 2;
  localparam int PW = $clog2(NP);

  rc6_state_e    st;
  logic [PW-1:0] rnd;
  logic          dec_q;
  logic          last_rnd;

  assign st_o      = st;
  assign ready     = (st == ST_IDLE);
  assign key_take  = ready && key_avail;
  assign load_en   = ready && blk_avail && !key_avail;
  assign round_en  = (st == ST_ROUND);
  assign post_en   = (st == ST_POST);
  assign blk_write = (st == ST_OUT) && !out_full;
  assign dec_mode  = ready ? dir_dec : dec_q;
  assign last_rnd  = dec_q ? (rnd == PW'(1)) : (rnd == PW'(R));

  always_comb begin
    unique case (st)
      ST_IDLE:  key_pair = dir_dec ? PW'(R+1) : '0;
      ST_ROUND: key_pair = rnd;
      ST_POST:  key_pair = dec_q ? '0 : PW'(R+1);
      default:  key_pair = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      rnd   <= '0;
      dec_q <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (load_en) begin
          st    <= ST_ROUND;
          dec_q <= dir_dec;
          rnd   <= dir_dec ? PW'(R) : PW'(1);
        end
        ST_ROUND: begin
          if (last_rnd) st <= ST_POST;
          else          rnd <= dec_q ? rnd - PW'(1) : rnd + PW'(1);
        end
        ST_POST: st <= ST_OUT;
        ST_OUT:  if (!out_full) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R4
  take_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> !ready);

  // R9
  write_returns_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_write |=> (ready && !blk_write));

  // R7
  round_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    round_en |-> (rnd >= PW'(1) && rnd <= PW'(R)));

  // R8
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OUT && out_full) |=> (st == ST_OUT));
endmodule

// File: rtl/rc6_iter_core.sv
module rc6_iter_core
  import rc6_pkg::*;
#(
  parameter int W = 32,
  parameter int R = 20
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           dir_dec,
  input  logic [4*W-1:0] blk_in,
  input  logic           blk_avail,
  output logic           blk_take,
  output logic [4*W-1:0] blk_out,
  output logic           blk_write,
  input  logic           out_full,
  input  logic [W-1:0]   key_word,
  input  logic           key_avail,
  output logic           key_take,
  output logic           ready
);
  localparam int NP = R + 2;
  localparam int PW = $clog2(NP);

  rc6_state_e    st;
  logic [PW-1:0] key_pair;
  logic          dec_mode, load_en, round_en, post_en;
  logic [W-1:0]  ke, ko;
  logic [W-1:0]  ra, rb, rc, rd;
  logic [W-1:0]  na, nb, nc, nd;
  logic [W-1:0]  ia, ib, ic, id;

  assign {id, ic, ib, ia} = blk_in;
  assign blk_out  = {rd, rc, rb, ra};
  assign blk_take = load_en;

  rc6_ctrl #(.R(R)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .dir_dec   (dir_dec),
    .blk_avail (blk_avail),
    .key_avail (key_avail),
    .out_full  (out_full),
    .st_o      (st),
    .key_pair  (key_pair),
    .dec_mode  (dec_mode),
    .load_en   (load_en),
    .round_en  (round_en),
    .post_en   (post_en),
    .key_take  (key_take),
    .blk_write (blk_write),
    .ready     (ready)
  );

  rc6_keymem #(.W(W), .R(R)) keys_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (key_take),
    .wr_data  (key_word),
    .rd_pair  (key_pair),
    .key_even (ke),
    .key_odd  (ko)
  );

  rc6_round #(.W(W)) round_i (
    .dec_i (dec_mode),
    .a_i   (ra),
    .b_i   (rb),
    .c_i   (rc),
    .d_i   (rd),
    .ke_i  (ke),
    .ko_i  (ko),
    .a_o   (na),
    .b_o   (nb),
    .c_o   (nc),
    .d_o   (nd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ra <= '0; rb <= '0; rc <= '0; rd <= '0;
    end else if (load_en) begin
      if (dec_mode) begin
        ra <= ia - ke;  rb <= ib;
        rc <= ic - ko;  rd <= id;
      end else begin
        ra <= ia;       rb <= ib + ke;
        rc <= ic;       rd <= id + ko;
      end
    end else if (round_en) begin
      ra <= na; rb <= nb; rc <= nc; rd <= nd;
    end else if (post_en) begin
      if (dec_mode) begin
        rb <= rb - ke;
        rd <= rd - ko;
      end else begin
        ra <= ra + ke;
        rc <= rc + ko;
      end
    end
  end

  // R8
  out_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OUT && out_full) |=> $stable(blk_out));

  // R4
  key_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_avail |-> !blk_take);
endmodule

// File: tb/rc6_iter_core_tb_top.sv
module rc6_iter_core_tb_top;
  localparam int W  = 32;
  localparam int R  = 20;
  localparam int NK = 2*R + 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           dir_dec = 1'b0;
  logic [4*W-1:0] blk_in = '0;
  logic           blk_avail = 1'b0;
  logic           blk_take;
  logic [4*W-1:0] blk_out;
  logic           blk_write;
  logic           out_full = 1'b0;
  logic [W-1:0]   key_word = '0;
  logic           key_avail = 1'b0;
  logic           key_take;
  logic           ready;

  int checks = 0;
  int errors = 0;
  int cycnt = 0;
  int take_cyc = 0;
  bit lat_on = 1'b1;
  logic [31:0] seed = 32'h1234_5678;
  logic [31:0] skey [NK];

  logic [4*W-1:0] exp_q [$];
  string          tag_q [$];

  always #5 clk = ~clk;

  rc6_iter_core #(.W(W), .R(R)) dut_i (
    .clk(clk), .rst_n(rst_n), .dir_dec(dir_dec), .blk_in(blk_in),
    .blk_avail(blk_avail), .blk_take(blk_take), .blk_out(blk_out),
    .blk_write(blk_write), .out_full(out_full), .key_word(key_word),
    .key_avail(key_avail), .key_take(key_take), .ready(ready)
  );

  task automatic check(input bit ok, input string req, input logic [4*W-1:0] act, input logic [4*W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt_rand();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    if (n == 0) return x;
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [31:0] quad(input logic [31:0] x);
    logic [31:0] sq;
    sq = x * (x + x + 32'd1);
    return rl(sq, 5);
  endfunction

  function automatic logic [127:0] ref_enc(input logic [127:0] p);
    logic [31:0] a, b, c, d, t, u, tmp;
    a = p[31:0]; b = p[63:32]; c = p[95:64]; d = p[127:96];
    b = b + skey[0];
    d = d + skey[1];
    for (int i = 1; i <= R; i++) begin
      t = quad(b);
      u = quad(d);
      a = rl(a ^ t, int'(u % 32)) + skey[2*i];
      c = rl(c ^ u, int'(t % 32)) + skey[2*i+1];
      tmp = a; a = b; b = c; c = d; d = tmp;
    end
    a = a + skey[2*R+2];
    c = c + skey[2*R+3];
    return {d, c, b, a};
  endfunction

  // driver: offers a block and queues the result it must produce
  task automatic send_block(input logic [127:0] data, input bit dec,
                            input logic [127:0] expv, input string req);
    exp_q.push_back(expv);
    tag_q.push_back(req);
    @(negedge clk);
    blk_in = data;
    dir_dec = dec;
    blk_avail = 1'b1;
    #1;
    while (!blk_take) begin
      @(negedge clk);
      #1;
    end
    take_cyc = cycnt;
    @(negedge clk);
    blk_avail = 1'b0;
    dir_dec = ~dec;  // R3: direction must only matter at acceptance
    blk_in = ~data;
  endtask

  task automatic load_keys(input int first);
    for (int k = first; k < NK; k++) begin
      @(negedge clk);
      key_avail = 1'b1;
      key_word = skey[k];
      #1;
      check(key_take == 1'b1, "R2 key_take", 128'(key_take), 128'd1);
    end
    @(negedge clk);
    key_avail = 1'b0;
  endtask

  // monitor: pops the scoreboard whenever a result is written
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (blk_write) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected write", blk_out, '0);
        end else begin
          automatic logic [127:0] e = exp_q.pop_front();
          automatic string tg = tag_q.pop_front();
          check(blk_out === e, tg, blk_out, e);
          if (lat_on)
            check(cycnt - take_cyc == R + 2, "R7 latency",
                  128'(cycnt - take_cyc), 128'(R + 2));
        end
      end
    end
  end

  always @(posedge clk) begin
    cycnt <= cycnt + 1;
    if (cycnt == 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=done", cycnt);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  logic [127:0] pts [8];
  logic [127:0] cts [8];

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check(ready == 1'b1,     "R1 ready",     128'(ready), 128'd1);
    check(blk_take == 1'b0,  "R1 blk_take",  128'(blk_take), 128'd0);
    check(blk_write == 1'b0, "R1 blk_write", 128'(blk_write), 128'd0);
    check(key_take == 1'b0,  "R1 key_take",  128'(key_take), 128'd0);

    for (int k = 0; k < NK; k++) skey[k] = nxt_rand();

    // R4: key has priority over a waiting block
    @(negedge clk);
    key_avail = 1'b1;
    key_word = skey[0];
    blk_avail = 1'b1;
    blk_in = 128'h5;
    #1;
    check(key_take == 1'b1 && blk_take == 1'b0, "R4 key priority",
          {126'd0, key_take, blk_take}, 128'd2);
    blk_avail = 1'b0;
    load_keys(1);

    pts[0] = '0;
    pts[1] = '1;
    pts[2] = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;
    for (int n = 3; n < 8; n++)
      pts[n] = {nxt_rand(), nxt_rand(), nxt_rand(), nxt_rand()};

    // R5 encryption, R3 packing
    for (int n = 0; n < 8; n++) begin
      cts[n] = ref_enc(pts[n]);
      send_block(pts[n], 1'b0, cts[n], "R5 encrypt");
    end
    // R6 decryption restores plaintext
    for (int n = 0; n < 8; n++)
      send_block(cts[n], 1'b1, pts[n], "R6 decrypt");

    // R8 back-pressure
    wait (exp_q.size() == 0);
    @(negedge clk);
    out_full = 1'b1;
    lat_on = 1'b0;
    send_block(pts[4], 1'b0, cts[4], "R8 held encrypt");
    for (int n = 0; n < R + 6; n++) begin
      @(negedge clk);
      #1;
      check(blk_write == 1'b0, "R8 no write while full", 128'(blk_write), 128'd0);
    end
    begin
      automatic logic [127:0] held = blk_out;
      check(held == cts[4], "R8 held value", held, cts[4]);
      blk_in = pts[5];
      dir_dec = 1'b0;
      blk_avail = 1'b1;
      for (int n = 0; n < 4; n++) begin
        @(negedge clk);
        #1;
        check(blk_take == 1'b0 && ready == 1'b0, "R8 no new take",
              {126'd0, blk_take, ready}, 128'd0);
        check(blk_out == held, "R8 stable", blk_out, held);
      end
      blk_avail = 1'b0;
    end
    @(negedge clk);
    out_full = 1'b0;
    #1;
    check(blk_write == 1'b1, "R8 write after release", 128'(blk_write), 128'd1);
    @(negedge clk);
    #1;
    check(ready == 1'b1 && blk_write == 1'b0, "R9 idle after write",
          {126'd0, ready, blk_write}, 128'd2);
    lat_on = 1'b1;

    // R2 second full load wraps the index and replaces the table
    for (int k = 0; k < NK; k++) skey[k] = nxt_rand();
    load_keys(0);
    for (int n = 0; n < 3; n++) begin
      cts[n] = ref_enc(pts[n + 2]);
      send_block(pts[n + 2], 1'b0, cts[n], "R2 new table encrypt");
      send_block(cts[n], 1'b1, pts[n + 2], "R6 new table decrypt");
    end

    wait (exp_q.size() == 0);
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule